// File: doc/BRIEF.md
# Staged PLL divider register bank

This block holds the divider settings for a clock-generator PLL: a 10-bit feedback divider N and a 7-bit reference divider M. A mode bit picks where the live dividers come from. With the bit clear, they come from a frequency lookup, which arrives on an input port. With the bit set, they come from values that software has programmed.

Software reaches three byte registers through a plain byte-write port and a combinational read port. The port stands in for a serial management bus. The bytes are:

- **CTRL**: bits [7:3] are reserved, bit 2 is the mode bit and bits [1:0] hold N[9:8].
- **NLO**: holds N[7:0].
- **MREF**: bit 7 is reserved and bits [6:0] hold M.

Writes to the divider fields only load staging registers. The programmed M and N take effect together when MREF is written, and only in override mode. The live outputs are registered. Each change of value or source is flagged to the PLL logic by a one-cycle pulse.

Top module: `pll_div_regbank`

## Requirements
- R1: After reset the registers read CTRL=0x00, NLO=0x4B and MREF=0x12. The register addresses are CTRL=0, NLO=1 and MREF=2. While reset is held, live_m, live_n and div_update are 0.
- R2: While the mode bit (CTRL bit 2) is 0, live_m and live_n equal the values tbl_m and tbl_n had one clock edge earlier.
- R3: A write to NLO is ignored while the mode bit is 0. In a CTRL write, bits [1:0] are stored only if the mode bit was already 1 before the write. Bits [7:2] are always stored.
- R4: A write to MREF while the mode bit is 0 changes neither the stored byte nor the outputs, and raises no div_update.
- R5: With the mode bit at 1, writes to CTRL and NLO change neither live_m nor live_n and raise no div_update.
- R6: With the mode bit at 1, a write to MREF sets the following after that same clock edge:
  - live_m = wr_data[6:0];
  - live_n = {CTRL[1:0], NLO} as staged;
  - div_update = 1 for one cycle.
- R7: One edge after the mode bit changes, the live outputs take the other source: the committed programmed set, or the table. div_update is 1 in that cycle only.
- R8: Reads return the staged byte, including the reserved bits as they were written. An unmapped address reads 0.
- R9: The committed programmed set out of reset is N=75 and M=18. It is live after entering override mode with no MREF write.
- R10: While the mode bit is 0, changes on tbl_m and tbl_n never raise div_update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 4 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 4 | Read address |
| rd_data | output | 8 | Staged byte at rd_addr |
| tbl_m | input | 7 | M from the frequency lookup |
| tbl_n | input | 10 | N from the frequency lookup |
| live_m | output | 7 | Live reference divider |
| live_n | output | 10 | Live feedback divider |
| ovr_mode | output | 1 | Current mode bit |
| div_update | output | 1 | One-cycle pulse when the live dividers change value or source |

## Verification
A staging register that takes a write it should have refused shows up on rd_data at the very next read. It may also show up on live_m or live_n, but only when a later commit or mode switch brings it out, which can be many cycles away. A wrong commit or a wrong source choice shows on live_m, live_n and div_update one edge after the write or the mode change. The reference model is compared on every cycle, so a missing or extra pulse is caught in the cycle it occurs.

// File: rtl/pll_div_regbank.sv
module pll_div_regbank #(
  parameter int ADDR_W = 4,
  parameter int N_W = 10,
  parameter int M_W = 7,
  parameter logic [ADDR_W-1:0] A_CTRL = 0,
  parameter logic [ADDR_W-1:0] A_NLO = 1,
  parameter logic [ADDR_W-1:0] A_MREF = 2,
  parameter logic [7:0] DEF_CTRL = 8'h00,
  parameter logic [7:0] DEF_NLO = 8'h4B,
  parameter logic [7:0] DEF_MREF = 8'h12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  input  logic [M_W-1:0]    tbl_m,
  input  logic [N_W-1:0]    tbl_n,
  output logic [M_W-1:0]    live_m,
  output logic [N_W-1:0]    live_n,
  output logic              ovr_mode,
  output logic              div_update
);
  localparam int NHI_W = N_W - 8;

  logic [7:0]     ctrl_q, nlo_q, mref_q;
  logic [M_W-1:0] prog_m;
  logic [N_W-1:0] prog_n;
  logic           src_q;

  wire wr_ctrl = wr_en && (wr_addr == A_CTRL);
  wire wr_nlo  = wr_en && (wr_addr == A_NLO);
  wire wr_mref = wr_en && (wr_addr == A_MREF);
  wire commit  = wr_mref && ovr_mode;
  wire [N_W-1:0] staged_n = {ctrl_q[NHI_W-1:0], nlo_q};

  assign ovr_mode = ctrl_q[2];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= DEF_CTRL;
      nlo_q  <= DEF_NLO;
      mref_q <= DEF_MREF;
    end else begin
      if (wr_ctrl)
        ctrl_q <= {wr_data[7:NHI_W], ovr_mode ? wr_data[NHI_W-1:0] : ctrl_q[NHI_W-1:0]};
      if (wr_nlo && ovr_mode)
        nlo_q <= wr_data;
      if (commit)
        mref_q <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_m     <= DEF_MREF[M_W-1:0];
      prog_n     <= {DEF_CTRL[NHI_W-1:0], DEF_NLO};
      live_m     <= '0;
      live_n     <= '0;
      src_q      <= 1'b0;
      div_update <= 1'b0;
    end else begin
      src_q      <= ovr_mode;
      div_update <= commit || (ovr_mode != src_q);
      if (commit) begin
        prog_m <= wr_data[M_W-1:0];
        prog_n <= staged_n;
        live_m <= wr_data[M_W-1:0];
        live_n <= staged_n;
      end else if (ovr_mode) begin
        live_m <= prog_m;
        live_n <= prog_n;
      end else begin
        live_m <= tbl_m;
        live_n <= tbl_n;
      end
    end
  end

  always_comb begin
    rd_data = 8'h00;
    if (rd_addr == A_CTRL)      rd_data = ctrl_q;
    else if (rd_addr == A_NLO)  rd_data = nlo_q;
    else if (rd_addr == A_MREF) rd_data = mref_q;
  end
endmodule

module pll_div_regbank_chk #(
  parameter int ADDR_W = 4,
  parameter int N_W = 10,
  parameter int M_W = 7,
  parameter logic [ADDR_W-1:0] A_NLO = 1,
  parameter logic [ADDR_W-1:0] A_MREF = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [7:0]        wr_data,
  input logic [M_W-1:0]    tbl_m,
  input logic [N_W-1:0]    tbl_n,
  input logic [M_W-1:0]    live_m,
  input logic [N_W-1:0]    live_n,
  input logic              ovr_mode,
  input logic              div_update,
  input logic [7:0]        nlo_q,
  input logic [7:0]        mref_q
);
  AST_TBL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !ovr_mode && !$past(ovr_mode)) |-> (live_m == $past(tbl_m) && live_n == $past(tbl_n))); // R2
  AST_NLO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_NLO && !ovr_mode) |=> $stable(nlo_q)); // R3
  AST_MREF_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MREF && !ovr_mode) |=> $stable(mref_q)); // R4
  AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && ovr_mode && $past(ovr_mode) && !div_update) |-> ($stable(live_m) && $stable(live_n))); // R5
  AST_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_MREF && ovr_mode) |=> (div_update && live_m == $past(wr_data[M_W-1:0]))); // R6
  AST_MODE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(ovr_mode) != $past(ovr_mode, 2)) |-> div_update); // R7
endmodule

bind pll_div_regbank pll_div_regbank_chk #(
  .ADDR_W(ADDR_W), .N_W(N_W), .M_W(M_W), .A_NLO(A_NLO), .A_MREF(A_MREF)
) u_chk (.*);

// File: tb/sim_pll_div_regbank.sv
module sim_pll_div_regbank;
  logic clk = 0, rst_n = 0, wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic [6:0] tbl_m = 7'd9, live_m;
  logic [9:0] tbl_n = 10'd300, live_n;
  logic ovr_mode, div_update;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pll_div_regbank u0 (.*);

  int c_res, c_mode, c_nhi, c_nlo, c_mref, p_m, p_n, l_m, l_n, s_src, s_upd;

  function automatic int read_model(int a);
    if (a == 0) return c_res * 8 + c_mode * 4 + c_nhi;
    if (a == 1) return c_nlo;
    if (a == 2) return c_mref;
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      c_res = 0; c_mode = 0; c_nhi = 0; c_nlo = 'h4B; c_mref = 'h12;
      p_m = 18; p_n = 75; l_m = 0; l_n = 0; s_src = 0; s_upd = 0;
    end else begin
      int a, d, m0, cm;
      a = wr_addr; d = wr_data; m0 = c_mode;
      cm = (wr_en && a == 2 && m0 == 1) ? 1 : 0;
      s_upd = (cm == 1 || m0 != s_src) ? 1 : 0;
      s_src = m0;
      if (cm == 1) begin
        l_m = d % 128; l_n = c_nhi * 256 + c_nlo; p_m = l_m; p_n = l_n;
      end else if (m0 == 1) begin
        l_m = p_m; l_n = p_n;
      end else begin
        l_m = tbl_m; l_n = tbl_n;
      end
      if (wr_en) begin
        if (a == 0) begin
          c_res = d / 8; c_mode = (d / 4) % 2;
          if (m0 == 1) c_nhi = d % 4;
        end else if (a == 1 && m0 == 1) c_nlo = d;
        else if (cm == 1) c_mref = d;
      end
    end
  end

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
    end
  endtask

  always @(negedge clk) if (!done) begin
    chk("MODEL live_m", live_m, l_m);
    chk("MODEL live_n", live_n, l_n);
    chk("MODEL div_update", div_update, s_upd);
    chk("MODEL rd_data", rd_data, read_model(rd_addr));
  end

  task automatic wr(int a, int d);
    @(negedge clk); #1; wr_en = 1; wr_addr = 4'(a); wr_data = 8'(d);
    @(negedge clk); #1; wr_en = 0;
  endtask

  task automatic rd(int a, int exp, string tag);
    @(negedge clk); #1; rd_addr = 4'(a);
    @(negedge clk); chk(tag, rd_data, exp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 live_m in reset", live_m, 0);
    chk("R1 upd in reset", div_update, 0);
    #1 rst_n = 1;
    rd(0, 'h00, "R1 ctrl default");
    rd(1, 'h4B, "R1 nlo default");
    rd(2, 'h12, "R1 mref default");
    chk("R2 live_m table", live_m, 9);
    chk("R2 live_n table", live_n, 300);
    @(negedge clk); #1 tbl_m = 7'd33; tbl_n = 10'd700;
    @(negedge clk);
    chk("R2 live_n follows", live_n, 700);
    chk("R10 no pulse on table", div_update, 0);
    wr(1, 'h55);
    rd(1, 'h4B, "R3 nlo locked");
    wr(0, 'h03);
    rd(0, 'h00, "R3 nhi locked");
    wr(2, 'h7F);
    chk("R4 no pulse", div_update, 0);
    rd(2, 'h12, "R4 mref locked");
    wr(0, 'hF4);
    @(negedge clk);
    chk("R7 pulse on entry", div_update, 1);
    chk("R9 default m", live_m, 18);
    chk("R9 default n", live_n, 75);
    rd(0, 'hF4, "R8 reserved ctrl bits");
    wr(0, 'hF6);
    wr(1, 'h34);
    chk("R5 no pulse", div_update, 0);
    chk("R5 live_n held", live_n, 75);
    rd(1, 'h34, "R8 staged nlo");
    wr(2, 'h85);
    chk("R6 commit pulse", div_update, 1);
    chk("R6 live_m", live_m, 5);
    chk("R6 live_n", live_n, 'h234);
    rd(2, 'h85, "R8 reserved mref bit");
    wr(0, 'h00);
    @(negedge clk);
    chk("R7 pulse on exit", div_update, 1);
    chk("R7 table back", live_m, 33);
    rd(5, 0, "R8 unmapped");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #50000;
    if (!done) begin
      done = 1; checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule